// File: doc/BRIEF.md
# Dual ADC Sample-Timing Controller

This block sequences the sampling and conversion timing of two analog-to-digital converters, called A (index 0) and B (index 1). On an accepted trigger a converter raises its sample-enable for a programmable window, then holds its busy output for a fixed conversion phase of 12 clocks, then pulses done for one clock. The window length comes from a 4-bit code per converter that selects one of seven power-of-two widths from 4 to 256 clocks. The code values that select no width raise an error flag and stop any conversion from starting.

The converters either run from their own triggers or both start from trigger A. In the shared mode a 4-bit phase value delays the start of converter B's sampling by 0 to 15 clocks relative to converter A. Each converter captures its window and delay when it accepts a trigger. A trigger that reaches a converter while it is still occupied is dropped and sets a sticky overrun bit for that converter.

Top module: `adc_pair_timer`

## Requirements
- R1: Width code 2k (k = 0..6, so codes 0x0, 0x2, 0x4, 0x6, 0x8, 0xA, 0xC) gives a sample window of 4 << k clocks. sample_o[i] goes high in the clock after the edge that accepts the trigger and stays high for exactly that many clocks.
- R2: If either width code is odd or above 0xC, cfg_err_o is high and no trigger starts either converter.
- R3: busy_o[i] is high for exactly 12 clocks, starting in the clock right after sample_o[i] falls. sample_o[i] and busy_o[i] are never high together.
- R4: done_o[i] is a single-clock pulse in the clock after busy_o[i] falls. The converter accepts a new trigger in that same clock, without an overrun.
- R5: With shared_trig_i low, trig_a_i starts only converter A and trig_b_i starts only converter B. phase_i has no effect.
- R6: With shared_trig_i high, trig_a_i starts both converters and trig_b_i has no effect.
- R7: With shared_trig_i high, converter B's sampling starts phase_i clocks after converter A's. With phase_i = 0 they start in the same clock.
- R8: A trigger that arrives while a converter is delaying, sampling or busy does not change that converter's timing. It sets overrun_o[i], which then stays high until reset.
- R9: The width codes and phase_i are captured when a trigger is accepted. Changing them during a conversion does not alter that conversion.
- R10: While reset is held and right after it, all sample, busy, done and overrun outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shared_trig_i | input | 1 | 1: trig_a_i starts both converters, with B lagged by phase_i |
| trig_a_i | input | 1 | Trigger for converter A (and B in shared mode) |
| trig_b_i | input | 1 | Trigger for converter B in independent mode |
| width_code_a_i | input | 4 | Sample window code for converter A |
| width_code_b_i | input | 4 | Sample window code for converter B |
| phase_i | input | 4 | Lag of converter B in clocks, in shared mode |
| sample_o | output | 2 | Sample-enable per converter |
| busy_o | output | 2 | Conversion-phase busy per converter |
| done_o | output | 2 | One-clock done strobe per converter |
| overrun_o | output | 2 | Sticky flag for a trigger dropped while occupied |
| cfg_err_o | output | 1 | Invalid width code present |

## Verification
Every valid width code is run once and every output is compared clock by clock. This separates the seven window lengths from one another and from an off-by-one at either end of the sample or busy phase. Independent and shared trigger patterns, including a trigger on the unused input, show whether each trigger is routed to the right converter. Shared runs at phase 0, 5 and 15 show whether the lag is exact. Retriggering in mid-conversion, in the done clock and after a mid-run configuration change separates a dropped trigger from a restart, checks that the done clock can accept a new start, and checks that configuration is captured at the trigger.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SAMPLE,
    ST_CONV
  } unit_state_e;
endpackage

// File: rtl/width_decoder.sv
module width_decoder #(
  parameter int CODE_W  = 4,
  parameter int MIN_LOG = 2,
  parameter int N_SIZES = 7,
  parameter int CNT_W   = MIN_LOG + N_SIZES
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  win_o,
  output logic              err_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'((N_SIZES - 1) * 2);

  logic [CODE_W-2:0] size_sel;

  assign size_sel = code_i[CODE_W-1:1];
  assign err_o    = code_i[0] | (code_i > MAX_CODE);

  always_comb begin
    win_o = '0;
    if (!err_o) win_o = CNT_W'(1) << (int'(size_sel) + MIN_LOG);
  end
endmodule

// File: rtl/conv_unit.sv
module conv_unit
  import adc_pair_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int PHASE_W  = 4,
  parameter int CONV_CYC = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               block_i,
  input  logic [CNT_W-1:0]   win_i,
  input  logic [PHASE_W-1:0] dly_i,
  output logic               sample_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               ovr_o
);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);

  unit_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_q;
  logic             done_q;
  logic             ovr_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (trig_i && state_q != ST_IDLE) ovr_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i && !block_i) begin
            win_q <= win_i;
            if (dly_i == '0) begin
              state_q <= ST_SAMPLE;
              cnt_q   <= win_i - 1'b1;
            end else begin
              state_q <= ST_DELAY;
              cnt_q   <= CNT_W'(dly_i) - 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (cnt_zero) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= win_q - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (cnt_zero) begin
            state_q <= ST_CONV;
            cnt_q   <= CONV_LAST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o = (state_q == ST_SAMPLE);
  assign busy_o   = (state_q == ST_CONV);
  assign done_o   = done_q;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/adc_pair_timer.sv
module adc_pair_timer #(
  parameter int CODE_W   = 4,
  parameter int PHASE_W  = 4,
  parameter int MIN_LOG  = 2,
  parameter int N_SIZES  = 7,
  parameter int CONV_CYC = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shared_trig_i,
  input  logic               trig_a_i,
  input  logic               trig_b_i,
  input  logic [CODE_W-1:0]  width_code_a_i,
  input  logic [CODE_W-1:0]  width_code_b_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [1:0]         sample_o,
  output logic [1:0]         busy_o,
  output logic [1:0]         done_o,
  output logic [1:0]         overrun_o,
  output logic               cfg_err_o
);
  localparam int N_CONV = 2;
  localparam int CNT_W  = MIN_LOG + N_SIZES;

  logic [CODE_W-1:0]  code  [N_CONV];
  logic [CNT_W-1:0]   win   [N_CONV];
  logic [PHASE_W-1:0] dly   [N_CONV];
  logic [N_CONV-1:0]  trig;
  logic [N_CONV-1:0]  err;

  always_comb begin
    code[0] = width_code_a_i;
    code[1] = width_code_b_i;
    trig[0] = trig_a_i;
    trig[1] = shared_trig_i ? trig_a_i : trig_b_i;
    dly[0]  = '0;
    dly[1]  = shared_trig_i ? phase_i : '0;
  end

  assign cfg_err_o = |err;

  for (genvar i = 0; i < N_CONV; i++) begin : g_conv
    width_decoder #(
      .CODE_W (CODE_W),
      .MIN_LOG(MIN_LOG),
      .N_SIZES(N_SIZES),
      .CNT_W  (CNT_W)
    ) i_dec (
      .code_i(code[i]),
      .win_o (win[i]),
      .err_o (err[i])
    );

    conv_unit #(
      .CNT_W   (CNT_W),
      .PHASE_W (PHASE_W),
      .CONV_CYC(CONV_CYC)
    ) i_unit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig[i]),
      .block_i (cfg_err_o),
      .win_i   (win[i]),
      .dly_i   (dly[i]),
      .sample_o(sample_o[i]),
      .busy_o  (busy_o[i]),
      .done_o  (done_o[i]),
      .ovr_o   (overrun_o[i])
    );
  end
endmodule

// File: rtl/adc_pair_timer_chk.sv
module adc_pair_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trig_a_i,
  input logic [1:0] sample_o,
  input logic [1:0] busy_o,
  input logic [1:0] done_o,
  input logic [1:0] overrun_o,
  input logic       cfg_err_o
);
  // R2: converter A only starts sampling from an accepted, unblocked trigger
  assert_err_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o[0]) |-> $past(trig_a_i && !cfg_err_o));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_phase_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sample_o[i] && busy_o[i]));

    assert_conv_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sample_o[i]) |-> busy_o[i]);

    assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[i] |-> ($past(busy_o[i]) && !busy_o[i]));

    assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[i] |=> !done_o[i]);

    assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o[i] |=> overrun_o[i]);
  end
endmodule

bind adc_pair_timer adc_pair_timer_chk i_chk (.*);

// File: tb/test_adc_pair_timer.sv
module test_adc_pair_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shared_trig_i = 1'b0;
  logic       trig_a_i = 1'b0;
  logic       trig_b_i = 1'b0;
  logic [3:0] width_code_a_i = 4'h0;
  logic [3:0] width_code_b_i = 4'h0;
  logic [3:0] phase_i = 4'h0;
  logic [1:0] sample_o, busy_o, done_o, overrun_o;
  logic       cfg_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  adc_pair_timer i_adc_pair_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shared_trig_i (shared_trig_i),
    .trig_a_i      (trig_a_i),
    .trig_b_i      (trig_b_i),
    .width_code_a_i(width_code_a_i),
    .width_code_b_i(width_code_b_i),
    .phase_i       (phase_i),
    .sample_o      (sample_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .overrun_o     (overrun_o),
    .cfg_err_o     (cfg_err_o)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // {done, busy, sample} expected k clocks after the accepting edge
  function automatic logic [2:0] exp_bits(int k, int w, int d);
    if (k >= d && k < d + w) return 3'b001;
    if (k >= d + w && k < d + w + 12) return 3'b010;
    if (k == d + w + 12) return 3'b100;
    return 3'b000;
  endfunction

  task automatic run_case(string req, logic fire_a, logic fire_b,
                          int wa, int da, logic ena, int wb, int db, logic enb,
                          int poke_k, logic poke_trig, logic [3:0] poke_code,
                          logic [3:0] poke_phase);
    int last = ((da + wa) > (db + wb) ? (da + wa) : (db + wb)) + 14;
    int mis_a = 0, mis_b = 0;
    logic [2:0] got_a = '0, exp_a = '0, got_b = '0, exp_b = '0;
    @(negedge clk_i);
    trig_a_i = fire_a;
    trig_b_i = fire_b;
    @(posedge clk_i);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk_i);
      trig_a_i = 1'b0;
      trig_b_i = 1'b0;
      if (k == poke_k) begin
        trig_a_i       = poke_trig;
        width_code_a_i = poke_code;
        phase_i        = poke_phase;
      end
      if ({done_o[0], busy_o[0], sample_o[0]} != (ena ? exp_bits(k, wa, da) : 3'b000)) begin
        if (mis_a == 0) begin
          got_a = {done_o[0], busy_o[0], sample_o[0]};
          exp_a = ena ? exp_bits(k, wa, da) : 3'b000;
        end
        mis_a++;
      end
      if ({done_o[1], busy_o[1], sample_o[1]} != (enb ? exp_bits(k, wb, db) : 3'b000)) begin
        if (mis_b == 0) begin
          got_b = {done_o[1], busy_o[1], sample_o[1]};
          exp_b = enb ? exp_bits(k, wb, db) : 3'b000;
        end
        mis_b++;
      end
    end
    check(mis_a == 0, req, "conv A {done,busy,sample} first mismatch", int'(got_a), int'(exp_a));
    check(mis_b == 0, req, "conv B {done,busy,sample} first mismatch", int'(got_b), int'(exp_b));
  endtask

  task automatic t_reset();
    check(sample_o == 2'b00 && busy_o == 2'b00 && done_o == 2'b00 && overrun_o == 2'b00,
          "R10", "outputs after reset", {sample_o, busy_o, done_o, overrun_o}, 0);
    check(cfg_err_o == 1'b0, "R2", "cfg_err with valid codes", cfg_err_o, 0);
  endtask

  task automatic t_windows();
    shared_trig_i = 1'b0;
    width_code_b_i = 4'h0;
    for (int c = 0; c < 7; c++) begin
      width_code_a_i = 4'(2 * c);
      run_case("R1 R3 R4", 1'b1, 1'b0, 4 << c, 0, 1'b1, 0, 0, 1'b0, -1, 1'b0, 4'(2 * c), phase_i);
    end
  endtask

  task automatic t_bad_codes();
    logic [3:0] bad [4] = '{4'h1, 4'hB, 4'hD, 4'hF};
    for (int j = 0; j < 4; j++) begin
      width_code_a_i = bad[j];
      #1;
      check(cfg_err_o == 1'b1, "R2", "cfg_err for bad code A", cfg_err_o, 1);
      run_case("R2", 1'b1, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0, -1, 1'b0, bad[j], phase_i);
    end
    width_code_a_i = 4'h2;
    width_code_b_i = 4'h3;
    #1;
    check(cfg_err_o == 1'b1, "R2", "cfg_err for bad code B", cfg_err_o, 1);
    run_case("R2", 1'b1, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0, -1, 1'b0, 4'h2, phase_i);
    width_code_b_i = 4'h0;
    #1;
    check(cfg_err_o == 1'b0, "R2", "cfg_err cleared", cfg_err_o, 0);
  endtask

  task automatic t_independent();
    shared_trig_i = 1'b0;
    phase_i = 4'h7;
    width_code_a_i = 4'h0;
    width_code_b_i = 4'h4;
    run_case("R5", 1'b0, 1'b1, 0, 0, 1'b0, 16, 0, 1'b1, -1, 1'b0, 4'h0, 4'h7);
    width_code_a_i = 4'h2;
    width_code_b_i = 4'h0;
    run_case("R5", 1'b1, 1'b1, 8, 0, 1'b1, 4, 0, 1'b1, -1, 1'b0, 4'h2, 4'h7);
    run_case("R5", 1'b1, 1'b0, 8, 0, 1'b1, 0, 0, 1'b0, -1, 1'b0, 4'h2, 4'h7);
  endtask

  task automatic t_shared();
    shared_trig_i = 1'b1;
    width_code_a_i = 4'h4;
    width_code_b_i = 4'h4;
    phase_i = 4'h0;
    run_case("R6 R7", 1'b1, 1'b0, 16, 0, 1'b1, 16, 0, 1'b1, -1, 1'b0, 4'h4, 4'h0);
    width_code_a_i = 4'h2;
    width_code_b_i = 4'h6;
    phase_i = 4'h5;
    run_case("R7", 1'b1, 1'b0, 8, 0, 1'b1, 32, 5, 1'b1, -1, 1'b0, 4'h2, 4'h5);
    width_code_a_i = 4'h0;
    width_code_b_i = 4'h0;
    phase_i = 4'hF;
    run_case("R7", 1'b1, 1'b0, 4, 0, 1'b1, 4, 15, 1'b1, -1, 1'b0, 4'h0, 4'hF);
    run_case("R6", 1'b0, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0, -1, 1'b0, 4'h0, 4'hF);
  endtask

  task automatic t_config_capture();
    shared_trig_i = 1'b1;
    width_code_a_i = 4'h0;
    width_code_b_i = 4'h0;
    phase_i = 4'h3;
    run_case("R9", 1'b1, 1'b0, 4, 0, 1'b1, 4, 3, 1'b1, 1, 1'b0, 4'hC, 4'h0);
    width_code_a_i = 4'hC;
    shared_trig_i = 1'b0;
    phase_i = 4'h0;
    run_case("R9 R1", 1'b1, 1'b0, 256, 0, 1'b1, 0, 0, 1'b0, -1, 1'b0, 4'hC, 4'h0);
  endtask

  task automatic t_back_to_back();
    shared_trig_i = 1'b0;
    width_code_a_i = 4'h0;
    @(negedge clk_i);
    trig_a_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);  // k = 0
    trig_a_i = 1'b0;
    repeat (16) @(negedge clk_i);  // k = 16, done clock
    check(done_o[0] == 1'b1, "R4", "done in clock after busy", done_o[0], 1);
    trig_a_i = 1'b1;
    @(negedge clk_i);
    trig_a_i = 1'b0;
    check(sample_o[0] == 1'b1 && done_o[0] == 1'b0, "R4", "restart from done clock",
          {done_o[0], sample_o[0]}, 1);
    repeat (20) @(negedge clk_i);
    check(overrun_o == 2'b00, "R4", "no overrun on done-clock trigger", overrun_o, 0);
  endtask

  task automatic t_overrun();
    shared_trig_i = 1'b0;
    width_code_a_i = 4'h4;
    run_case("R8", 1'b1, 1'b0, 16, 0, 1'b1, 0, 0, 1'b0, 3, 1'b1, 4'h4, 4'h0);
    check(overrun_o == 2'b01, "R8", "overrun flag after retrigger", overrun_o, 1);
    repeat (5) @(negedge clk_i);
    check(overrun_o == 2'b01, "R8", "overrun flag sticky", overrun_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_windows();
    t_bad_codes();
    t_independent();
    t_shared();
    t_config_capture();
    t_back_to_back();
    t_overrun();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule